// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command front end of a byte-wide parallel NOR flash model. It watches an asynchronous bus made of chip-enable, write-enable and output-enable strobes (all active low), a 19-bit address and an 8-bit data path. It brings those signals into one system clock, captures the address and data of each write cycle, and tracks multi-write command sequences. Each sequence has to begin with a fixed two-write unlock prefix.

When a sequence completes, the block sends a one-cycle command pulse to a separate embedded-operation engine. The pulse carries an opcode, the latched address and the latched data. An engine busy input drives a selective lockout: while a program runs, nothing is accepted; while a sector erase runs, only suspend and resume are accepted. The block also tells the read path where read data comes from: the array, the identifier codes, or the operation status.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, rd_src is 0 (array), id_byte is 00h and no command pulse is issued.
- R2: A write cycle is the span during which both ce_n and we_n are low. The address is taken when that span begins and the data when it ends, and each span yields exactly one write event.
- R3: The unlock prefix is AAh written to 555h and then 55h written to 2AAh. The prefix, then A0h to 555h, then a data write to any address issues cmd_op 3 (program) with that write's address and data on cmd_addr and cmd_data.
- R4: Prefix, 80h to 555h, a second prefix, then 10h to 555h issues cmd_op 4 (chip erase). If the last write is instead 30h to any address, it issues cmd_op 5 (sector erase) with that address.
- R5: Prefix, then 90h to 555h, issues cmd_op 2 and sets rd_src to 1 (identifier). In that mode id_byte is C2h when addr[1:0]=00, 4Fh when it is 01, and 00h otherwise. Bits above addr[1] do not matter.
- R6: F0h written to any address, outside a program data cycle, issues cmd_op 1 (reset) and returns rd_src to 0.
- R7: A write with an unexpected address or data at any step drops the partial sequence and leaves identifier mode. A following command byte without a fresh prefix then issues nothing.
- R8: Only addr[10:0] take part in matching unlock and command writes. addr[18:11] are ignored.
- R9: While eng_busy is high after a program or chip erase, every write is ignored, including F0h and complete sequences.
- R10: While eng_busy is high after a sector erase, B0h to any address issues cmd_op 6 (suspend), and rd_src becomes 0. While suspended, 30h issues cmd_op 7 (resume). All other writes are ignored.
- R11: rd_src is 2 (status) while eng_busy is high and no suspend is in effect.
- R12: cmd_valid is never high on two consecutive cycles.
- R13: rd_active is high when the synchronized ce_n and oe_n are low and we_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Asynchronous chip enable, active low |
| we_n | input | 1 | Asynchronous write enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 19 | Bus address |
| wdata | input | 8 | Bus write data |
| eng_busy | input | 1 | Embedded operation in progress |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Command opcode |
| cmd_addr | output | 19 | Address latched with the command |
| cmd_data | output | 8 | Data latched with the command |
| rd_active | output | 1 | Read cycle in progress |
| rd_src | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| id_byte | output | 8 | Identifier byte for the current address |

## Verification
Some properties are checked by assertions on every cycle. Each write span gives a single event pulse, and command pulses are never back to back. A program pulse only follows the program-data step, and a suspend pulse only appears while the engine is busy. Writes made under a program or chip erase lockout never produce a pulse. Only the bench scenarios can show the rest: the full sequences, the abort paths, the masking of the high address bits, the identifier codes, and the order of suspend and resume along with their effect on the read source.

// File: rtl/flash_cmd_pkg.sv
// Shared types for the flash command decoder: opcodes, sequence states and
// the kind of long operation that holds the lockout.
package flash_cmd_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_RESET  = 3'd1,
        OP_IDENT  = 3'd2,
        OP_PROG   = 3'd3,
        OP_CHIP   = 3'd4,
        OP_SECT   = 3'd5,
        OP_SUSP   = 3'd6,
        OP_RESUME = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_UNL1, S_UNL2, S_PDATA, S_ERA1, S_ERA2, S_ERA3
    } seq_e;

    typedef enum logic [1:0] {
        LK_NONE, LK_PROG, LK_CHIP, LK_SECT
    } lock_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_STATUS = 2'd2
    } rdsrc_e;
endpackage

// File: rtl/fcd_bus_sync.sv
// Bus front end. Synchronizes the asynchronous strobes into clk and forms the
// write span (ce_n and we_n both low). It latches the address when the span
// begins and the data when it ends, then pulses wr_evt once.
// Assumes addr is stable through the span and wdata stays stable for
// SYNC_STAGES+1 cycles after it ends.
module fcd_bus_sync #(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_active
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] ce_sh, we_sh, oe_sh;
    logic          span, span_d;

    // Synchronizer chains for the three strobes, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_sh <= '1;
            we_sh <= '1;
            oe_sh <= '1;
        end else begin
            ce_sh <= {ce_sh[LAST-1:0], ce_n};
            we_sh <= {we_sh[LAST-1:0], we_n};
            oe_sh <= {oe_sh[LAST-1:0], oe_n};
        end
    end

    assign span      = !ce_sh[LAST] && !we_sh[LAST];
    assign rd_active = !ce_sh[LAST] && !oe_sh[LAST] && we_sh[LAST];

    // Edge tracking of the write span, address and data capture, event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_d  <= 1'b0;
            wr_evt  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            span_d <= span;
            wr_evt <= 1'b0;
            if (span && !span_d) wr_addr <= addr;
            if (!span && span_d) begin
                wr_data <= wdata;
                wr_evt  <= 1'b1;
            end
        end
    end

    a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt);
endmodule

// File: rtl/fcd_seq_fsm.sv
// Sequence tracker. Matches unlock prefixes and command bytes on the low
// MATCH_W address bits, issues one-cycle command pulses and applies the
// lockout while the engine reports busy. Assumes wr_evt pulses are at least
// two cycles apart.
module fcd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int MATCH_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_busy,
    output logic              cmd_valid,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              id_mode,
    output logic              suspended
);
    localparam logic [MATCH_W-1:0] K_A = MATCH_W'('h555);
    localparam logic [MATCH_W-1:0] K_B = MATCH_W'('h2AA);
    localparam logic [DATA_W-1:0]  D_UNL1  = DATA_W'('hAA);
    localparam logic [DATA_W-1:0]  D_UNL2  = DATA_W'('h55);
    localparam logic [DATA_W-1:0]  D_PROG  = DATA_W'('hA0);
    localparam logic [DATA_W-1:0]  D_ERASE = DATA_W'('h80);
    localparam logic [DATA_W-1:0]  D_IDENT = DATA_W'('h90);
    localparam logic [DATA_W-1:0]  D_RESET = DATA_W'('hF0);
    localparam logic [DATA_W-1:0]  D_CHIP  = DATA_W'('h10);
    localparam logic [DATA_W-1:0]  D_SECT  = DATA_W'('h30);
    localparam logic [DATA_W-1:0]  D_SUSP  = DATA_W'('hB0);

    seq_e  state, nxt_state;
    lock_e lock_kind, nxt_lock;
    logic  nxt_id, nxt_susp, issue;
    op_e   nxt_op;
    logic  at_a, at_b, is_unl1, is_unl2, is_reset;

    assign at_a     = wr_addr[MATCH_W-1:0] == K_A;
    assign at_b     = wr_addr[MATCH_W-1:0] == K_B;
    assign is_unl1  = at_a && wr_data == D_UNL1;
    assign is_unl2  = at_b && wr_data == D_UNL2;
    assign is_reset = wr_data == D_RESET;

    // Next-state decode: lockout first, then the sequence steps.
    always_comb begin
        nxt_state = state;
        nxt_lock  = lock_kind;
        nxt_id    = id_mode;
        nxt_susp  = eng_busy ? suspended : 1'b0;
        issue     = 1'b0;
        nxt_op    = OP_NONE;
        if (wr_evt) begin
            if (eng_busy) begin
                if (lock_kind == LK_SECT) begin
                    if (!suspended && wr_data == D_SUSP) begin
                        issue = 1'b1; nxt_op = OP_SUSP; nxt_susp = 1'b1;
                    end else if (suspended && wr_data == D_SECT) begin
                        issue = 1'b1; nxt_op = OP_RESUME; nxt_susp = 1'b0;
                    end
                end
            end else begin
                nxt_state = S_IDLE;
                if (state == S_PDATA) begin
                    issue = 1'b1; nxt_op = OP_PROG; nxt_lock = LK_PROG; nxt_id = 1'b0;
                end else if (is_reset) begin
                    issue = 1'b1; nxt_op = OP_RESET; nxt_id = 1'b0;
                end else begin
                    unique case (state)
                        S_IDLE: if (is_unl1) nxt_state = S_UNL1; else nxt_id = 1'b0;
                        S_UNL1: if (is_unl2) nxt_state = S_UNL2; else nxt_id = 1'b0;
                        S_UNL2: begin
                            if (at_a && wr_data == D_PROG)       nxt_state = S_PDATA;
                            else if (at_a && wr_data == D_ERASE) nxt_state = S_ERA1;
                            else if (at_a && wr_data == D_IDENT) begin
                                issue = 1'b1; nxt_op = OP_IDENT; nxt_id = 1'b1;
                            end else nxt_id = 1'b0;
                        end
                        S_ERA1: if (is_unl1) nxt_state = S_ERA2; else nxt_id = 1'b0;
                        S_ERA2: if (is_unl2) nxt_state = S_ERA3; else nxt_id = 1'b0;
                        S_ERA3: begin
                            nxt_id = 1'b0;
                            if (at_a && wr_data == D_CHIP) begin
                                issue = 1'b1; nxt_op = OP_CHIP; nxt_lock = LK_CHIP;
                            end else if (wr_data == D_SECT) begin
                                issue = 1'b1; nxt_op = OP_SECT; nxt_lock = LK_SECT;
                            end
                        end
                        default: nxt_id = 1'b0;
                    endcase
                end
            end
        end
    end

    // State registers and the registered command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            lock_kind <= LK_NONE;
            id_mode   <= 1'b0;
            suspended <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_op    <= OP_NONE;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            state     <= nxt_state;
            lock_kind <= nxt_lock;
            id_mode   <= nxt_id;
            suspended <= nxt_susp;
            cmd_valid <= issue;
            if (issue) begin
                cmd_op   <= nxt_op;
                cmd_addr <= wr_addr;
                cmd_data <= wr_data;
            end
        end
    end

    a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    a_r9_locked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && eng_busy && lock_kind != LK_SECT) |=> !cmd_valid);
    a_r3_prog_after_a0: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PROG) |-> $past(state) == S_PDATA);
    a_r10_suspend_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SUSP) |-> $past(eng_busy));
endmodule

// File: rtl/fcd_read_steer.sv
// Read steering. Picks the read source from the busy and suspend state and
// the identifier mode, and forms the identifier byte from the low address
// bits. Purely combinational.
module fcd_read_steer
    import flash_cmd_pkg::*;
#(
    parameter int           DATA_W = 8,
    parameter logic [7:0]   MFR_ID = 8'hC2,
    parameter logic [7:0]   DEV_ID = 8'h4F
) (
    input  logic              eng_busy,
    input  logic              suspended,
    input  logic              id_mode,
    input  logic [1:0]        addr_lo,
    output logic [1:0]        rd_src,
    output logic [DATA_W-1:0] id_byte
);
    // Source priority: status, then identifier, then array.
    always_comb begin
        if (eng_busy && !suspended) rd_src = RD_STATUS;
        else if (id_mode)           rd_src = RD_IDENT;
        else                        rd_src = RD_ARRAY;
    end

    // Identifier code selected by the two lowest address bits.
    always_comb begin
        id_byte = '0;
        if (id_mode) begin
            unique case (addr_lo)
                2'b00:   id_byte = DATA_W'(MFR_ID);
                2'b01:   id_byte = DATA_W'(DEV_ID);
                default: id_byte = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder: bus synchronizer, sequence tracker and
// read steering. Assumes one system clock and well-separated bus cycles.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 8,
    parameter int MATCH_W     = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              rd_active,
    output logic [1:0]        rd_src,
    output logic [DATA_W-1:0] id_byte
);
    logic              wr_evt, id_mode, suspended;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    op_e               op_q;

    fcd_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_active(rd_active));

    fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH_W(MATCH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_busy(eng_busy), .cmd_valid(cmd_valid),
        .cmd_op(op_q), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .id_mode(id_mode), .suspended(suspended));

    assign cmd_op = op_q;

    fcd_read_steer #(.DATA_W(DATA_W)) u_rd (
        .eng_busy(eng_busy), .suspended(suspended), .id_mode(id_mode),
        .addr_lo(addr[1:0]), .rd_src(rd_src), .id_byte(id_byte));
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        eng_busy = 1'b0;
    logic        cmd_valid, rd_active;
    logic [2:0]  cmd_op;
    logic [18:0] cmd_addr;
    logic [7:0]  cmd_data, id_byte;
    logic [1:0]  rd_src;

    int n_chk = 0, n_bad = 0, n_cmd = 0, n_double = 0;
    logic [2:0]  last_op;
    logic [18:0] last_addr;
    logic [7:0]  last_data;
    logic        prev_valid = 1'b0;

    flash_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .eng_busy(eng_busy), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rd_active(rd_active), .rd_src(rd_src), .id_byte(id_byte));

    always #2 clk = ~clk;

    // Pulse monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (cmd_valid) begin
            n_cmd++;
            last_op = cmd_op; last_addr = cmd_addr; last_data = cmd_data;
            if (prev_valid) n_double++;
        end
        prev_valid = cmd_valid;
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [18:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic unlock(logic [18:0] hi);
        bus_write(hi | 19'h555, 8'hAA);
        bus_write(hi | 19'h2AA, 8'h55);
    endtask

    task automatic t_reset_state;
        check("R1 rd_src", rd_src, 0);
        check("R1 id_byte", id_byte, 0);
        check("R1 no pulse", n_cmd, 0);
    endtask

    task automatic t_program;
        int c0 = n_cmd;
        unlock('0);
        bus_write(19'h555, 8'hA0);
        check("R3 no pulse before data", n_cmd, c0);
        bus_write(19'h4_1234, 8'h5A);
        check("R3 one pulse", n_cmd, c0 + 1);
        check("R3 op", last_op, 3);
        check("R2 R3 addr", last_addr, 19'h4_1234);
        check("R2 R3 data", last_data, 8'h5A);
    endtask

    task automatic t_erase;
        int c0 = n_cmd;
        unlock('0); bus_write(19'h555, 8'h80); unlock('0);
        bus_write(19'h555, 8'h10);
        check("R4 chip pulse", n_cmd, c0 + 1);
        check("R4 chip op", last_op, 4);
        unlock('0); bus_write(19'h555, 8'h80); unlock('0);
        bus_write(19'h3_0042, 8'h30);
        check("R4 sector pulse", n_cmd, c0 + 2);
        check("R4 sector op", last_op, 5);
        check("R4 sector addr", last_addr, 19'h3_0042);
    endtask

    task automatic rd_cycle(logic [18:0] a, output logic [7:0] idv, output logic act);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        idv = id_byte; act = rd_active;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_autoselect;
        logic [7:0] v; logic act;
        unlock(19'h7_F800);
        bus_write(19'h7_F800 | 19'h555, 8'h90);
        check("R5 R8 ident op", last_op, 2);
        check("R5 rd_src ident", rd_src, 1);
        rd_cycle(19'h5_5AA0, v, act);
        check("R5 mfr code", v, 8'hC2);
        check("R13 rd_active", act, 1);
        rd_cycle(19'h0_7FFD, v, act);
        check("R5 dev code", v, 8'h4F);
        rd_cycle(19'h0_0002, v, act);
        check("R5 other code", v, 8'h00);
        check("R13 idle", rd_active, 0);
        bus_write(19'h1_2345, 8'hF0);
        check("R6 reset op", last_op, 1);
        check("R6 rd_src array", rd_src, 0);
    endtask

    task automatic t_abort;
        int c0 = n_cmd;
        unlock('0); bus_write(19'h555, 8'h90);
        bus_write(19'h556, 8'hAA);
        check("R7 ident cleared", rd_src, 0);
        c0 = n_cmd;
        bus_write(19'h555, 8'hAA);
        bus_write(19'h2AA, 8'h54);
        bus_write(19'h555, 8'hA0);
        bus_write(19'h100, 8'h11);
        check("R7 no pulse after bad data", n_cmd, c0);
        unlock('0); bus_write(19'h555, 8'h80);
        bus_write(19'h555, 8'h55);
        bus_write(19'h555, 8'h10);
        check("R7 erase abort", n_cmd, c0);
        bus_write(19'h7_FD55, 8'hAA);
        bus_write(19'h0_FAAA, 8'h55);
        bus_write(19'h6_0555, 8'hA0);
        bus_write(19'h0_0007, 8'h77);
        check("R8 high bits ignored", last_op, 3);
        check("R8 pulse", n_cmd, c0 + 1);
    endtask

    task automatic t_prog_lock;
        int c0;
        unlock('0); bus_write(19'h555, 8'hA0); bus_write(19'h10, 8'h01);
        eng_busy = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 status", rd_src, 2);
        c0 = n_cmd;
        bus_write(19'h0, 8'hF0);
        bus_write(19'h0, 8'hB0);
        unlock('0); bus_write(19'h555, 8'h90);
        check("R9 program lock", n_cmd, c0);
        eng_busy = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 rd_src after lock", rd_src, 0);
        bus_write(19'h0, 8'hF0);
        check("R9 accepted after busy", n_cmd, c0 + 1);
    endtask

    task automatic t_chip_lock;
        int c0;
        unlock('0); bus_write(19'h555, 8'h80); unlock('0); bus_write(19'h555, 8'h10);
        eng_busy = 1'b1;
        c0 = n_cmd;
        bus_write(19'h0, 8'hB0);
        bus_write(19'h0, 8'h30);
        check("R9 chip erase lock", n_cmd, c0);
        eng_busy = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_suspend;
        int c0;
        unlock('0); bus_write(19'h555, 8'h80); unlock('0); bus_write(19'h2_0000, 8'h30);
        eng_busy = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 status in erase", rd_src, 2);
        c0 = n_cmd;
        bus_write(19'h0, 8'h30);
        bus_write(19'h0, 8'hF0);
        check("R10 others ignored", n_cmd, c0);
        bus_write(19'h1_2345, 8'hB0);
        check("R10 suspend pulse", n_cmd, c0 + 1);
        check("R10 suspend op", last_op, 6);
        check("R10 array when suspended", rd_src, 0);
        bus_write(19'h0, 8'hB0);
        check("R10 second B0 ignored", n_cmd, c0 + 1);
        bus_write(19'h0, 8'h30);
        check("R10 resume op", last_op, 7);
        check("R10 resume pulse", n_cmd, c0 + 2);
        check("R11 status again", rd_src, 2);
        eng_busy = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 done", rd_src, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset_state();
        t_program();
        t_erase();
        t_autoselect();
        t_abort();
        t_prog_lock();
        t_chip_lock();
        t_suspend();
        check("R12 no back-to-back pulses", n_double, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule